// File: doc/BRIEF.md
# Processor Stop-Clock Power Sequencer

This block is the system-side sequencer that puts a processor to sleep and wakes it again. When software raises a sleep request, it raises the processor's stop request. It then supplies the write-buffer-empty indication, but never before the stop request. It watches the processor bus for the one special cycle that acknowledges the stop, and it answers that cycle with a one-cycle ready pulse.

Once the acknowledge has been answered, and if software allows deep sleep, the sequencer drops the clock-run enable that gates the processor clock. On wake it enables the clock first. It then holds the stop request for a programmable settling time and only after that releases it, which lets the processor resume.

A two-bit status output lets software see which phase the sequence is in. All outputs are active high. Polarity conversion to the bus pins happens outside the block.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After synchronous reset, the outputs are stpclk_o=0, ewbe_o=0, brdy_o=0 and clk_run_o=1, and status_o=0. The status codes are 0 = RUN, 1 = STOP_REQ, 2 = STOP_GRANT and 3 = STOP_CLOCK.
- R2: In RUN with sleep_req=1 at a clock edge, stpclk_o is 1 and status_o is 1 from the next cycle.
- R3: ewbe_o equals stpclk_o AND wbuf_empty, so it is never 1 while stpclk_o is 0.
- R4: In STOP_REQ, a cycle strobe (bus_ads=1) that carries the stop-acknowledge encoding produces brdy_o=1 for exactly one cycle, starting the next cycle, and status_o becomes 2. The encoding is bus_dc=0, bus_mio=0, bus_wr=1, bus_be=8'hFB and bus_addr (address bits 31..3) = 29'h10.
- R5: In STOP_REQ, a strobed cycle that differs from that encoding in any field, or matching fields presented without the strobe, gives no brdy_o, and status_o stays 1.
- R6: Dropping sleep_req during STOP_REQ does not release stpclk_o. The block stays in STOP_REQ until the acknowledge cycle arrives.
- R7: In STOP_GRANT with sleep_req=1 and deep_ok=1, clk_run_o falls to 0 at the next edge and status_o becomes 3. clk_run_o is 0 only while stpclk_o is 1, and only after the ready pulse has been returned.
- R8: In STOP_GRANT with sleep_req=0, the block returns to RUN at the next edge: stpclk_o becomes 0 and the clock is never gated.
- R9: In STOP_CLOCK with sleep_req=0, clk_run_o returns to 1 at the next edge, and status_o reads 2 while the clock settles. stpclk_o stays 1 and falls exactly wake_dly+1 cycles after clk_run_o rose, with wake_dly sampled at that edge.
- R10: The acknowledge encoding presented in RUN or in STOP_GRANT gives no brdy_o.
- R11: In STOP_GRANT with deep_ok=0 and sleep_req=1, the clock keeps running and status_o stays 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (free running) |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Software sleep request (1 = sleep, 0 = wake) |
| deep_ok | input | 1 | Software permits gating of the processor clock |
| wake_dly | input | 16 | Clock settling cycles, minus one, before the stop request is released |
| wbuf_empty | input | 1 | System write buffers drained |
| bus_ads | input | 1 | Processor bus cycle strobe |
| bus_dc | input | 1 | Data/code indicator of the cycle |
| bus_mio | input | 1 | Memory/IO indicator of the cycle |
| bus_wr | input | 1 | Write/read indicator of the cycle |
| bus_be | input | 8 | Byte enables |
| bus_addr | input | 29 | Address bits 31..3 |
| stpclk_o | output | 1 | Stop request to the processor |
| ewbe_o | output | 1 | Write-buffer-empty indication to the processor |
| brdy_o | output | 1 | Ready returned for the acknowledge cycle |
| clk_run_o | output | 1 | Processor clock enable (0 = clock stopped) |
| status_o | output | 2 | Sequence phase code (see R1) |

## Verification
The hardest point to reach from the ports is the wake path: it needs the acknowledge cycle, then deep sleep, then the release of the sleep request, and only then does the settling count start. The bench walks this whole chain in order. It counts sampled cycles between the rise of clk_run_o and the fall of stpclk_o, once with a nonzero delay and once with a delay of zero. A vector table applies a single-field corruption of the acknowledge encoding to each field in turn, so that a decoder that ignores any one field is exposed.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    localparam int DLY_W    = 16;
    localparam int BE_W     = 8;
    localparam int ADDR_W   = 29;

    localparam logic [BE_W-1:0]   SG_BE   = 8'hFB;
    localparam logic [ADDR_W-1:0] SG_ADDR = 29'h10;

    typedef struct packed {
        logic              ads;
        logic              dc;
        logic              mio;
        logic              wr;
        logic [BE_W-1:0]   be;
        logic [ADDR_W-1:0] addr;
    } bus_ctl_t;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_REQ,
        ST_GRANT,
        ST_GATED,
        ST_WAKE
    } pcc_state_e;

    typedef enum logic [1:0] {
        STAT_RUN        = 2'd0,
        STAT_STOP_REQ   = 2'd1,
        STAT_STOP_GRANT = 2'd2,
        STAT_STOP_CLOCK = 2'd3
    } pcc_status_e;

    function automatic pcc_status_e to_status(pcc_state_e s);
        case (s)
            ST_RUN:   return STAT_RUN;
            ST_REQ:   return STAT_STOP_REQ;
            ST_GRANT: return STAT_STOP_GRANT;
            ST_WAKE:  return STAT_STOP_GRANT;
            default:  return STAT_STOP_CLOCK;
        endcase
    endfunction

endpackage

// File: rtl/pcc_sg_decode.sv
module pcc_sg_decode
    import pcc_pkg::*;
(
    input  bus_ctl_t bus,
    output logic     hit
);
    logic ctl_ok;
    logic be_ok;
    logic addr_ok;

    always_comb begin
        ctl_ok  = bus.ads && !bus.dc && !bus.mio && bus.wr;
        be_ok   = (bus.be == SG_BE);
        addr_ok = (bus.addr == SG_ADDR);
        hit     = ctl_ok && be_ok && addr_ok;
    end
endmodule

// File: rtl/pcc_wake_timer.sv
module pcc_wake_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/pcc_fsm.sv
module pcc_fsm
    import pcc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sleep_req,
    input  logic        deep_ok,
    input  logic        sg_hit,
    input  logic        tmr_done,
    output logic        tmr_load,
    output logic        tmr_run,
    output logic        stpclk,
    output logic        brdy,
    output logic        clk_run,
    output pcc_status_e status
);
    pcc_state_e state_q;
    pcc_state_e state_d;
    logic       brdy_q;

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_run  = 1'b0;
        case (state_q)
            ST_RUN:   if (sleep_req) state_d = ST_REQ;
            ST_REQ:   if (sg_hit) state_d = ST_GRANT;
            ST_GRANT: begin
                if (!sleep_req)
                    state_d = ST_RUN;
                else if (deep_ok)
                    state_d = ST_GATED;
            end
            ST_GATED: begin
                if (!sleep_req) begin
                    state_d  = ST_WAKE;
                    tmr_load = 1'b1;
                end
            end
            ST_WAKE: begin
                tmr_run = 1'b1;
                if (tmr_done) state_d = ST_RUN;
            end
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            brdy_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            brdy_q  <= (state_q == ST_REQ) && sg_hit;
        end
    end

    assign stpclk  = (state_q != ST_RUN);
    assign clk_run = (state_q != ST_GATED);
    assign brdy    = brdy_q;
    assign status  = to_status(state_q);
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
    import pcc_pkg::*;
#(
    parameter int DLY_BITS = DLY_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sleep_req,
    input  logic                deep_ok,
    input  logic [DLY_BITS-1:0] wake_dly,
    input  logic                wbuf_empty,
    input  logic                bus_ads,
    input  logic                bus_dc,
    input  logic                bus_mio,
    input  logic                bus_wr,
    input  logic [BE_W-1:0]     bus_be,
    input  logic [ADDR_W-1:0]   bus_addr,
    output logic                stpclk_o,
    output logic                ewbe_o,
    output logic                brdy_o,
    output logic                clk_run_o,
    output logic [1:0]          status_o
);
    bus_ctl_t    bus;
    logic        sg_hit;
    logic        tmr_load;
    logic        tmr_run;
    logic        tmr_done;
    pcc_status_e status;

    assign bus = '{ads: bus_ads, dc: bus_dc, mio: bus_mio, wr: bus_wr,
                   be: bus_be, addr: bus_addr};

    pcc_sg_decode u_dec (
        .bus (bus),
        .hit (sg_hit)
    );

    pcc_wake_timer #(.W(DLY_BITS)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (wake_dly),
        .run      (tmr_run),
        .done     (tmr_done)
    );

    pcc_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_req),
        .deep_ok   (deep_ok),
        .sg_hit    (sg_hit),
        .tmr_done  (tmr_done),
        .tmr_load  (tmr_load),
        .tmr_run   (tmr_run),
        .stpclk    (stpclk_o),
        .brdy      (brdy_o),
        .clk_run   (clk_run_o),
        .status    (status)
    );

    assign ewbe_o   = stpclk_o && wbuf_empty;
    assign status_o = status;
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker (
    input logic       clk,
    input logic       rst,
    input logic       sleep_req,
    input logic       stpclk_o,
    input logic       ewbe_o,
    input logic       brdy_o,
    input logic       clk_run_o,
    input logic [1:0] status_o
);
    assert_ewbe_after_stop_R3: assert property (@(posedge clk) disable iff (rst)
        ewbe_o |-> stpclk_o);

    assert_sleep_raises_stop_R2: assert property (@(posedge clk) disable iff (rst)
        (status_o == 2'd0 && sleep_req) |=> stpclk_o);

    assert_brdy_in_grant_R4: assert property (@(posedge clk) disable iff (rst)
        brdy_o |-> status_o == 2'd2);

    assert_brdy_single_R4: assert property (@(posedge clk) disable iff (rst)
        brdy_o |=> !brdy_o);

    assert_req_holds_stop_R6: assert property (@(posedge clk) disable iff (rst)
        (status_o == 2'd1) |=> stpclk_o);

    assert_gate_under_stop_R7: assert property (@(posedge clk) disable iff (rst)
        !clk_run_o |-> stpclk_o);

    assert_gate_from_grant_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_run_o) |-> $past(status_o) == 2'd2);

    assert_release_clock_running_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(stpclk_o) |-> clk_run_o);

    assert_restart_before_release_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_run_o) |-> stpclk_o);
endmodule

bind pwr_clk_ctrl pcc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .sleep_req (sleep_req),
    .stpclk_o  (stpclk_o),
    .ewbe_o    (ewbe_o),
    .brdy_o    (brdy_o),
    .clk_run_o (clk_run_o),
    .status_o  (status_o)
);

// File: tb/sim_pwr_clk_ctrl.sv
module sim_pwr_clk_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 9;

    typedef struct packed {
        logic        ads;
        logic        dc;
        logic        mio;
        logic        wr;
        logic [7:0]  be;
        logic [28:0] addr;
        logic        exp;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'hFB, 29'h10,       1'b1},
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'hFB, 29'h10,       1'b0},
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'hFB, 29'h10,       1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'hFB, 29'h10,       1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, 29'h10,       1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'hFA, 29'h10,       1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'hFB, 29'h11,       1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'hFB, 29'h10000010, 1'b0},
        '{1'b0, 1'b0, 1'b0, 1'b1, 8'hFB, 29'h10,       1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sleep_req = 1'b0;
    logic        deep_ok = 1'b0;
    logic [15:0] wake_dly = '0;
    logic        wbuf_empty = 1'b0;
    logic        bus_ads = 1'b0;
    logic        bus_dc = 1'b1;
    logic        bus_mio = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_be = 8'hFF;
    logic [28:0] bus_addr = '0;
    logic        stpclk_o, ewbe_o, brdy_o, clk_run_o;
    logic [1:0]  status_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_clk_ctrl u0 (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .deep_ok(deep_ok),
        .wake_dly(wake_dly), .wbuf_empty(wbuf_empty), .bus_ads(bus_ads),
        .bus_dc(bus_dc), .bus_mio(bus_mio), .bus_wr(bus_wr), .bus_be(bus_be),
        .bus_addr(bus_addr), .stpclk_o(stpclk_o), .ewbe_o(ewbe_o),
        .brdy_o(brdy_o), .clk_run_o(clk_run_o), .status_o(status_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_sg();
        bus_ads = 1'b1; bus_dc = 1'b0; bus_mio = 1'b0; bus_wr = 1'b1;
        bus_be = 8'hFB; bus_addr = 29'h10;
    endtask

    task automatic idle_bus();
        bus_ads = 1'b0; bus_dc = 1'b1; bus_mio = 1'b1; bus_wr = 1'b0;
        bus_be = 8'hFF; bus_addr = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset state
        chk("R1 stpclk", stpclk_o, 0);
        chk("R1 ewbe", ewbe_o, 0);
        chk("R1 brdy", brdy_o, 0);
        chk("R1 clk_run", clk_run_o, 1);
        chk("R1 status", status_o, 0);

        // Decode table walk: R2, R4, R5, R8
        for (int i = 0; i < NVEC; i++) begin
            if (status_o != 2'd1) begin
                sleep_req = 1'b1;
                tick();
                chk("R2 stpclk", stpclk_o, 1);
                chk("R2 status", status_o, 1);
            end
            bus_ads = VEC[i].ads; bus_dc = VEC[i].dc; bus_mio = VEC[i].mio;
            bus_wr = VEC[i].wr; bus_be = VEC[i].be; bus_addr = VEC[i].addr;
            tick();
            idle_bus();
            if (VEC[i].exp) begin
                chk("R4 brdy", brdy_o, 1);
                chk("R4 status", status_o, 2);
                sleep_req = 1'b0;
                tick();
                chk("R4 brdy single", brdy_o, 0);
                chk("R8 status", status_o, 0);
                chk("R8 stpclk", stpclk_o, 0);
                chk("R8 clk_run", clk_run_o, 1);
            end else begin
                chk("R5 brdy", brdy_o, 0);
                chk("R5 status", status_o, 1);
            end
        end
        // leave STOP_REQ cleanly
        drive_sg(); tick(); idle_bus();
        chk("R4 brdy", brdy_o, 1);
        sleep_req = 1'b0; tick();
        chk("R8 status", status_o, 0);

        // R10 in RUN
        drive_sg(); tick(); idle_bus();
        chk("R10 brdy run", brdy_o, 0);
        chk("R10 status run", status_o, 0);

        // R3 ewbe ordering
        wbuf_empty = 1'b1; #1;
        chk("R3 ewbe in run", ewbe_o, 0);
        wbuf_empty = 1'b0; sleep_req = 1'b1; tick();
        chk("R3 ewbe not drained", ewbe_o, 0);
        wbuf_empty = 1'b1; #1;
        chk("R3 ewbe drained", ewbe_o, 1);

        // R6 sleep dropped before grant
        sleep_req = 1'b0;
        repeat (3) tick();
        chk("R6 stpclk", stpclk_o, 1);
        chk("R6 status", status_o, 1);
        sleep_req = 1'b1;

        drive_sg(); tick(); idle_bus();
        chk("R4 brdy", brdy_o, 1);
        // R10 in STOP_GRANT
        drive_sg(); tick(); idle_bus();
        chk("R10 brdy grant", brdy_o, 0);
        chk("R10 status grant", status_o, 2);

        // R11 deep sleep not allowed
        repeat (2) tick();
        chk("R11 status", status_o, 2);
        chk("R11 clk_run", clk_run_o, 1);

        // R7 gate the clock
        deep_ok = 1'b1; tick();
        chk("R7 status", status_o, 3);
        chk("R7 clk_run", clk_run_o, 0);
        chk("R7 stpclk", stpclk_o, 1);
        tick();
        chk("R7 hold", status_o, 3);

        // R9 wake with delay 3
        wake_dly = 16'd3; sleep_req = 1'b0; tick();
        chk("R9 clk_run", clk_run_o, 1);
        chk("R9 status settle", status_o, 2);
        chk("R9 stpclk held", stpclk_o, 1);
        n = 0;
        for (int k = 0; k < 100 && stpclk_o; k++) begin
            tick(); n++;
        end
        chk("R9 delay 3", n, 4);
        chk("R9 status run", status_o, 0);

        // R9 wake with delay 0
        sleep_req = 1'b1; tick();
        drive_sg(); tick(); idle_bus();
        tick();
        chk("R7 status again", status_o, 3);
        wake_dly = 16'd0; sleep_req = 1'b0; tick();
        chk("R9 clk_run d0", clk_run_o, 1);
        n = 0;
        for (int k = 0; k < 100 && stpclk_o; k++) begin
            tick(); n++;
        end
        chk("R9 delay 0", n, 1);

        // R1 reset from gated state
        sleep_req = 1'b1; tick();
        drive_sg(); tick(); idle_bus();
        tick();
        chk("R7 gated", clk_run_o, 0);
        rst = 1'b1; sleep_req = 1'b0; tick(); rst = 1'b0;
        chk("R1 clk_run after reset", clk_run_o, 1);
        chk("R1 status after reset", status_o, 0);
        chk("R1 stpclk after reset", stpclk_o, 0);

        finish_run();
    end
endmodule